// File: doc/BRIEF.md
# Four-Channel DAC Register Controller

This block is the digital control front end of a four-channel, 8-bit digital-to-analog converter. Software reaches it over a small peripheral register bus with an address, write data, a write strobe, a read strobe and read data. Behind the bus sit one control byte, whose low bits enable the channels one by one, and one byte-wide code register per channel.

For each channel the block drives the 8-bit code that goes to the converter, a flag that says the channel is active, a one-cycle pulse that marks the start of a conversion, and a settled flag. The settled flag rises a programmable number of cycles after the most recent start. A global idle input forces every channel inactive. The enable bits are kept while idle is asserted, so the channels come back without software help when idle is released. A channel that is not active always presents code zero.

Top module: `dac_ctl_top`

## Requirements
- R1: After reset the control register and all code registers hold zero, every channel is inactive with output code zero, and no start pulse or settled flag is asserted.
- R2: The control register sits at address 0. Bit i (i = 0..3) enables channel i. Bits 7 to 4 always read as zero, and writes to them are ignored.
- R3: The code register for channel i sits at address 1+i and can be read and written as a full byte. Read data appears after the clock edge that samples the read strobe and holds until the next read.
- R4: An inactive channel outputs code zero whatever its register holds. An active channel outputs its register value. A register write is visible on the channel outputs from the second rising edge counted from the edge that samples the write strobe.
- R5: While idle is high, all channels go inactive with code zero at the next edge. The enable bits are retained, and each enabled channel becomes active again at the edge after idle falls.
- R6: A write to an active channel's code register produces a start pulse of exactly one cycle on that channel, aligned with the new code on the output. A write to an inactive channel produces no pulse.
- R7: Addresses 5 to 7 read as zero, and writes to them change no register.
- R8: A channel that goes from inactive to active with a nonzero code produces one start pulse. With a zero code it produces none. When this transition falls in the same cycle as a pending code write, a single pulse results.
- R9: Every start pulse reloads the channel's settle counter with SETTLE_CYCLES. The settled flag is asserted exactly SETTLE_CYCLES cycles after the start pulse, and only while the channel is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wr_en | input | 1 | Write strobe |
| bus_wr_data | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rd_data | output | 8 | Registered read data |
| idle_i | input | 1 | Global idle, forces all channels inactive |
| ch_code_o | output | 32 | Output codes, channel i in bits 8i+7..8i |
| ch_active_o | output | 4 | Channel active flags |
| ch_start_o | output | 4 | One-cycle conversion start pulses |
| ch_settled_o | output | 4 | Settle-done flags |

## Verification
A code write and the inactive-to-active transition of the same channel can both trigger a start in the same cycle. The bench provokes this by writing a nonzero code while idle is high and dropping idle at the very next cycle, so that the pending write and the activation meet at one edge. The bench judges the result as correct only when a single one-cycle pulse appears, the new code is already on the output in that cycle, and the settle counter runs one full window from that pulse. Exhaustive sweeps of all control values and all code values on every channel cover the masking and forcing rules.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
    localparam int CTRL_ADDR      = 0;
    localparam int CODE_ADDR_BASE = 1;

    function automatic int code_addr(input int ch);
        return CODE_ADDR_BASE + ch;
    endfunction
endpackage

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs
    import dac_ctl_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     wr_en,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     rd_en,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_CH-1:0]        en_o,
    output logic [NUM_CH*DATA_W-1:0] code_o,
    output logic [NUM_CH-1:0]        hit_o
);
    typedef struct packed {
        logic [NUM_CH-1:0]             en;
        logic [NUM_CH-1:0][DATA_W-1:0] code;
        logic [NUM_CH-1:0]             hit;
        logic [DATA_W-1:0]             rdata;
    } regs_t;

    regs_t r_d, r_q;
    logic [DATA_W-1:0] rd_val;

    always_comb begin
        r_d    = r_q;
        r_d.hit = '0;
        rd_val = '0;
        if (addr == ADDR_W'(CTRL_ADDR))
            rd_val[NUM_CH-1:0] = r_q.en;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (addr == ADDR_W'(code_addr(ch)))
                rd_val = r_q.code[ch];
        end
        if (rd_en)
            r_d.rdata = rd_val;
        if (wr_en) begin
            if (addr == ADDR_W'(CTRL_ADDR))
                r_d.en = wr_data[NUM_CH-1:0];
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (addr == ADDR_W'(code_addr(ch))) begin
                    r_d.code[ch] = wr_data;
                    r_d.hit[ch]  = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data = r_q.rdata;
    assign en_o    = r_q.en;
    assign code_o  = r_q.code;
    assign hit_o   = r_q.hit;
endmodule

// File: rtl/dac_ctl_chan.sv
module dac_ctl_chan #(
    parameter int DATA_W        = 8,
    parameter int SETTLE_CYCLES = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              idle,
    input  logic [DATA_W-1:0] code,
    input  logic              hit,
    output logic              active_o,
    output logic [DATA_W-1:0] code_o,
    output logic              start_o,
    output logic              settled_o
);
    localparam int CNT_W = (SETTLE_CYCLES < 1) ? 1 : $clog2(SETTLE_CYCLES + 1);

    typedef struct packed {
        logic              active;
        logic [DATA_W-1:0] code;
        logic              start;
        logic [CNT_W-1:0]  cnt;
    } chan_t;

    chan_t c_d, c_q;
    logic  act_now;
    logic  go;

    always_comb begin
        act_now    = en & ~idle;
        go         = act_now & (hit | (~c_q.active & (code != '0)));
        c_d        = c_q;
        c_d.active = act_now;
        c_d.code   = act_now ? code : '0;
        c_d.start  = go;
        if (!act_now)
            c_d.cnt = '0;
        else if (go)
            c_d.cnt = CNT_W'(SETTLE_CYCLES);
        else if (c_q.cnt != '0)
            c_d.cnt = c_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign active_o  = c_q.active;
    assign code_o    = c_q.code;
    assign start_o   = c_q.start;
    assign settled_o = c_q.active & (c_q.cnt == '0);
endmodule

// File: rtl/dac_ctl_top.sv
module dac_ctl_top #(
    parameter int NUM_CH        = 4,
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 3,
    parameter int SETTLE_CYCLES = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic                     bus_wr_en,
    input  logic [DATA_W-1:0]        bus_wr_data,
    input  logic                     bus_rd_en,
    output logic [DATA_W-1:0]        bus_rd_data,
    input  logic                     idle_i,
    output logic [NUM_CH*DATA_W-1:0] ch_code_o,
    output logic [NUM_CH-1:0]        ch_active_o,
    output logic [NUM_CH-1:0]        ch_start_o,
    output logic [NUM_CH-1:0]        ch_settled_o
);
    logic [NUM_CH-1:0]        en;
    logic [NUM_CH*DATA_W-1:0] reg_code;
    logic [NUM_CH-1:0]        hit;

    dac_ctl_regs #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (bus_addr),
        .wr_en   (bus_wr_en),
        .wr_data (bus_wr_data),
        .rd_en   (bus_rd_en),
        .rd_data (bus_rd_data),
        .en_o    (en),
        .code_o  (reg_code),
        .hit_o   (hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        dac_ctl_chan #(
            .DATA_W        (DATA_W),
            .SETTLE_CYCLES (SETTLE_CYCLES)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en[g]),
            .idle      (idle_i),
            .code      (reg_code[g*DATA_W +: DATA_W]),
            .hit       (hit[g]),
            .active_o  (ch_active_o[g]),
            .code_o    (ch_code_o[g*DATA_W +: DATA_W]),
            .start_o   (ch_start_o[g]),
            .settled_o (ch_settled_o[g])
        );
    end
endmodule

// File: rtl/dac_ctl_checker.sv
module dac_ctl_checker #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic                     bus_rd_en,
    input logic [DATA_W-1:0]        bus_rd_data,
    input logic                     idle_i,
    input logic [NUM_CH*DATA_W-1:0] ch_code_o,
    input logic [NUM_CH-1:0]        ch_active_o,
    input logic [NUM_CH-1:0]        ch_start_o,
    input logic [NUM_CH-1:0]        ch_settled_o
);
    AST_IDLE_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
        idle_i |=> (ch_active_o == '0)); // R5

    AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd_en) && ($past(bus_addr) == '0)) |-> (bus_rd_data[DATA_W-1:NUM_CH] == '0)); // R2

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            !ch_active_o[g] |-> (ch_code_o[g*DATA_W +: DATA_W] == '0)); // R4

        AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_start_o[g] |-> ch_active_o[g]); // R6

        AST_RISE_START: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(ch_active_o[g]) && (ch_code_o[g*DATA_W +: DATA_W] != '0)) |-> ch_start_o[g]); // R8

        AST_SETTLED_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
            ch_settled_o[g] |-> ch_active_o[g]); // R9
    end
endmodule

bind dac_ctl_top dac_ctl_checker #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_rd_en    (bus_rd_en),
    .bus_rd_data  (bus_rd_data),
    .idle_i       (idle_i),
    .ch_code_o    (ch_code_o),
    .ch_active_o  (ch_active_o),
    .ch_start_o   (ch_start_o),
    .ch_settled_o (ch_settled_o)
);

// File: tb/dac_ctl_top_test.sv
module dac_ctl_top_test;
    localparam int S = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [7:0]  bus_wr_data = '0;
    logic        bus_rd_en = 1'b0;
    logic [7:0]  bus_rd_data;
    logic        idle_i = 1'b0;
    logic [31:0] ch_code_o;
    logic [3:0]  ch_active_o;
    logic [3:0]  ch_start_o;
    logic [3:0]  ch_settled_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [3:0] en_m   = '0;
    logic [7:0] code_m [4];
    logic [3:0] prev_m = '0;
    logic [3:0] hit_m  = '0;

    always #2.5 clk = ~clk;

    dac_ctl_top #(.SETTLE_CYCLES(S)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr_en    (bus_wr_en),
        .bus_wr_data  (bus_wr_data),
        .bus_rd_en    (bus_rd_en),
        .bus_rd_data  (bus_rd_data),
        .idle_i       (idle_i),
        .ch_code_o    (ch_code_o),
        .ch_active_o  (ch_active_o),
        .ch_start_o   (ch_start_o),
        .ch_settled_o (ch_settled_o)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        bus_addr = a; bus_wr_data = v; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
        if (a == 3'd0) en_m = v[3:0];
        else if (a <= 3'd4) begin
            code_m[a-1] = v;
            hit_m[a-1]  = 1'b1;
        end
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk(req, {24'h0, bus_rd_data}, {24'h0, exp});
    endtask

    // one cycle later: check active, codes and start pulses against the model
    task automatic step(input string req);
        logic [3:0]  act;
        logic [3:0]  st;
        logic [31:0] cd;
        @(negedge clk);
        act = idle_i ? 4'h0 : en_m;
        cd  = '0;
        for (int c = 0; c < 4; c++) begin
            st[c] = act[c] & (hit_m[c] | (~prev_m[c] & (code_m[c] != 8'h0)));
            if (act[c]) cd[c*8 +: 8] = code_m[c];
        end
        chk({req, " active"}, {28'h0, ch_active_o}, {28'h0, act});
        chk({req, " code"},   ch_code_o, cd);
        chk({req, " start"},  {28'h0, ch_start_o}, {28'h0, st});
        prev_m = act;
        hit_m  = '0;
    endtask

    task automatic settle_window(input int ch, input string req);
        int n = 0;
        chk({req, " settled low at start"}, {31'h0, ch_settled_o[ch]}, 32'h0);
        while (!ch_settled_o[ch] && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({req, " settle cycles"}, n, S);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) code_m[c] = 8'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 active",  {28'h0, ch_active_o}, 32'h0);
        chk("R1 code",    ch_code_o, 32'h0);
        chk("R1 start",   {28'h0, ch_start_o}, 32'h0);
        chk("R1 settled", {28'h0, ch_settled_o}, 32'h0);
        for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 readback");

        // R2: sweep every control value, reserved bits masked
        for (int v = 0; v < 256; v++) begin
            wr(3'd0, 8'(v));
            step("R2");
            rd(3'd0, 8'(v & 15), "R2 readback");
        end

        // R3 / R4 / R6: full code sweep, channels 0 and 2 active
        wr(3'd0, 8'h05);
        step("R2 enable");
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 256; v++) begin
                wr(3'(c + 1), 8'(v));
                step("R6");
            end
            rd(3'(c + 1), 8'hFF, "R3 readback");
        end
        step("R6 pulse ends");

        // R7: out-of-range addresses
        for (int a = 5; a < 8; a++) begin
            wr(3'(a), 8'hA5);
            step("R7");
            rd(3'(a), 8'h00, "R7 read");
        end
        for (int c = 0; c < 4; c++) rd(3'(c + 1), 8'hFF, "R7 untouched");
        rd(3'd0, 8'h05, "R7 ctrl untouched");

        // R4 / R8: load codes while disabled, then enable
        wr(3'd0, 8'h00);  step("R4 disable");
        wr(3'd1, 8'h11);  step("R4");
        wr(3'd2, 8'h00);  step("R4");
        wr(3'd3, 8'h80);  step("R4");
        wr(3'd4, 8'h01);  step("R4");
        wr(3'd0, 8'h0F);  step("R8 rise");
        step("R8 pulse ends");

        // R9: settle window from a fresh write on channel 3
        wr(3'd4, 8'h7E);
        step("R9 start");
        settle_window(3, "R9");
        prev_m = ch_active_o;

        // R5: idle overrides and enables return without rewrite
        idle_i = 1'b1; step("R5 idle");
        step("R5 idle hold");
        wr(3'd1, 8'h22); step("R6 write while idle");
        rd(3'd0, 8'h0F, "R5 enables retained");
        idle_i = 1'b0; step("R5 release");
        step("R5 after release");

        // R8: pending write and activation meet at one edge
        idle_i = 1'b1; step("R8 idle");
        wr(3'd2, 8'h3C);
        idle_i = 1'b0;
        step("R8 coincident");
        chk("R8 single pulse ch1", {31'h0, ch_start_o[1]}, 32'h1);
        settle_window(1, "R9 coincident");
        prev_m = ch_active_o;
        step("R8 no second pulse");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule